// File: doc/BRIEF.md
# Miss Latency Breakdown Profiler

This block takes completed memory request records and sorts their latencies into histograms. Each record has a request type, a responder class, a hit-or-miss flag and five timestamps: issue, initial request, forward, first response and completion. The total latency is the completion time minus the issue time. It is binned in every valid record into an overall histogram and into a per-type histogram. Hits and external misses then go to two separate histogram sets. Each set has one histogram per type and one per responder class.

For external misses the block also splits the latency into four phase segments and bins each segment per responder. It does this only when the timestamps run in non-decreasing order. When they do not, the block counts the record in a per-responder incomplete counter. A responder value at or above the number of classes means "no responder", and it skips every per-responder count. Counts are read back through a combinational port addressed by group, index and bucket. An active-low reset clears every count.

Top module: `lat_breakdown_prof`

## Requirements
- R1: On each cycle where `rec_valid` is high, the total latency `ts_done - ts_issue` (modulo 2^TS_W) is counted in the overall histogram (group 0, index 0). When `rec_type` is below NUM_TYPES, it is also counted in the per-type histogram (group 1, index = type).
- R2: A record with `rec_miss` low is counted in the hit-by-type histogram (group 2) and, with a valid responder, in the hit-by-responder histogram (group 4). It touches none of groups 3, 5, 6 or 7.
- R3: A record with `rec_miss` high is counted in the miss-by-type histogram (group 3) and, with a valid responder, in the miss-by-responder histogram (group 5). It touches neither group 2 nor group 4.
- R4: A responder value of NUM_RESP or more changes no per-responder count (groups 4, 5, 6, 7). The overall and per-type counts still update.
- R5: A miss with a valid responder r whose timestamps satisfy issue <= initial <= forward <= first <= done bins four deltas in group 6 at index 4*r+k. The deltas are k=0: initial-issue, k=1: forward-initial, k=2: first-forward, k=3: done-first.
- R6: A miss with a valid responder r whose timestamps break that order increments the incomplete counter r (group 7, index r, bucket ignored). It bins no segment.
- R7: A value v falls in bucket min(v >> BKT_SHIFT, NBKT-1), so a value past the last bucket is counted in the last bucket.
- R8: Every count saturates at 2^CNT_W-1 and never wraps.
- R9: While `rst_n` is low, every histogram bucket and every incomplete counter is zero.
- R10: `rd_count` combinationally returns the addressed count. Groups are 0 all, 1 type, 2 hit-type, 3 miss-type, 4 hit-responder, 5 miss-responder, 6 segment, 7 incomplete. An index beyond the group's size reads zero, and so does a bucket of NBKT or more in groups 0 to 6.
- R11: A `rec_type` of NUM_TYPES or more is left out of groups 1, 2 and 3. Its overall and responder counts still update.
- R12: A cycle with `rec_valid` low changes no count, whatever the other record inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all counts |
| rec_valid | input | 1 | A completion record is present this cycle |
| rec_type | input | TYPE_W | Request type |
| rec_resp | input | RESP_W | Responder class; NUM_RESP or more means none |
| rec_miss | input | 1 | 1 = external miss, 0 = hit |
| ts_issue | input | TS_W | Issue timestamp |
| ts_init | input | TS_W | Initial request timestamp |
| ts_fwd | input | TS_W | Forward timestamp |
| ts_first | input | TS_W | First response timestamp |
| ts_done | input | TS_W | Completion timestamp |
| rd_group | input | 3 | Histogram group select |
| rd_index | input | IDX_W | Histogram index within group |
| rd_bucket | input | BKT_W | Bucket select |
| rd_count | output | CNT_W | Addressed count |

## Verification
On every cycle the assertions check the following:
- A count under a read address held steady never decreases.
- A count held at its maximum stays there.
- Out-of-range buckets read zero.
- An idle cycle leaves the addressed count unchanged.
- A record with no responder leaves the responder groups alone.
- A hit leaves the miss-only groups alone.

Only the bench's scenarios can show that each record lands in the right bucket of the right histograms. These cover the segment split, the out-of-order case, out-of-range types and saturation under many repeats. After each scenario the bench compares the whole readable space against a model.

// File: rtl/lat_prof_pkg.sv
package lat_prof_pkg;

    typedef enum logic [2:0] {
        G_ALL       = 3'd0,
        G_TYPE      = 3'd1,
        G_HIT_TYPE  = 3'd2,
        G_MISS_TYPE = 3'd3,
        G_HIT_RESP  = 3'd4,
        G_MISS_RESP = 3'd5,
        G_SEG       = 3'd6,
        G_INCOMP    = 3'd7
    } grp_e;

    localparam int NSEG = 4;

endpackage

// File: rtl/lat_bucketer.sv
module lat_bucketer #(
    parameter int TS_W      = 16,
    parameter int NBKT      = 10,
    parameter int BKT_W     = 4,
    parameter int BKT_SHIFT = 3
) (
    input  logic [TS_W-1:0]  value,
    output logic [BKT_W-1:0] bucket
);

    logic [TS_W-1:0] scaled;

    always_comb begin
        scaled = value >> BKT_SHIFT;
        if (scaled >= TS_W'(NBKT - 1)) begin
            bucket = BKT_W'(NBKT - 1);
        end else begin
            bucket = scaled[BKT_W-1:0];
        end
    end

endmodule

// File: rtl/lat_hist_bank.sv
module lat_hist_bank #(
    parameter int NH    = 1,
    parameter int NBKT  = 10,
    parameter int BKT_W = 4,
    parameter int CNT_W = 16,
    parameter int IDX_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NH-1:0]             inc,
    input  logic [NH-1:0][BKT_W-1:0]  bkt,
    input  logic [IDX_W-1:0]          rd_hist,
    input  logic [BKT_W-1:0]          rd_bkt,
    output logic [CNT_W-1:0]          rd_cnt
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [NH-1:0][NBKT-1:0][CNT_W-1:0] cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < NH; h++) begin
            for (int b = 0; b < NBKT; b++) begin
                if (inc[h] && (bkt[h] == BKT_W'(b)) && (st_q.cnt[h][b] != CMAX)) begin
                    st_d.cnt[h][b] = st_q.cnt[h][b] + CNT_W'(1);
                end
            end
        end
    end

    always_comb begin
        rd_cnt = '0;
        for (int h = 0; h < NH; h++) begin
            for (int b = 0; b < NBKT; b++) begin
                if ((rd_hist == IDX_W'(h)) && (rd_bkt == BKT_W'(b))) begin
                    rd_cnt = st_q.cnt[h][b];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lat_breakdown_prof.sv
module lat_breakdown_prof
    import lat_prof_pkg::*;
#(
    parameter int NUM_TYPES = 4,
    parameter int NUM_RESP  = 3,
    parameter int TS_W      = 16,
    parameter int NBKT      = 10,
    parameter int BKT_SHIFT = 3,
    parameter int CNT_W     = 16,
    localparam int TYPE_W   = $clog2(NUM_TYPES),
    localparam int RESP_W   = $clog2(NUM_RESP + 1),
    localparam int BKT_W    = $clog2(NBKT),
    localparam int MAX_IDX  = (NUM_TYPES > NSEG * NUM_RESP) ? NUM_TYPES : NSEG * NUM_RESP,
    localparam int IDX_W    = $clog2(MAX_IDX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [TYPE_W-1:0] rec_type,
    input  logic [RESP_W-1:0] rec_resp,
    input  logic              rec_miss,
    input  logic [TS_W-1:0]   ts_issue,
    input  logic [TS_W-1:0]   ts_init,
    input  logic [TS_W-1:0]   ts_fwd,
    input  logic [TS_W-1:0]   ts_first,
    input  logic [TS_W-1:0]   ts_done,
    input  logic [2:0]        rd_group,
    input  logic [IDX_W-1:0]  rd_index,
    input  logic [BKT_W-1:0]  rd_bucket,
    output logic [CNT_W-1:0]  rd_count
);

    localparam int NSEGH = NSEG * NUM_RESP;

    // value 0 is the total, 1..4 the phase segments
    logic [NSEG:0][TS_W-1:0]  dv;
    logic [NSEG:0][BKT_W-1:0] bv;
    logic                     ordered;

    logic [NUM_TYPES-1:0] type_hit_v, hit_type_inc, miss_type_inc;
    logic [NUM_RESP-1:0]  resp_hit_v, hit_resp_inc, miss_resp_inc, incomp_inc;
    logic [NSEGH-1:0]     seg_inc;

    logic [NUM_TYPES-1:0][BKT_W-1:0] type_bkt;
    logic [NUM_RESP-1:0][BKT_W-1:0]  resp_bkt;
    logic [NSEGH-1:0][BKT_W-1:0]     seg_bkt;
    logic [NUM_RESP-1:0][0:0]        incomp_bkt;

    logic [CNT_W-1:0] c_all, c_type, c_htype, c_mtype, c_hresp, c_mresp, c_seg, c_inc;

    always_comb begin
        dv[0] = ts_done - ts_issue;
        dv[1] = ts_init - ts_issue;
        dv[2] = ts_fwd - ts_init;
        dv[3] = ts_first - ts_fwd;
        dv[4] = ts_done - ts_first;
        ordered = (ts_issue <= ts_init) && (ts_init <= ts_fwd) &&
                  (ts_fwd <= ts_first) && (ts_first <= ts_done);
    end

    for (genvar k = 0; k <= NSEG; k++) begin : g_bkt
        lat_bucketer #(
            .TS_W(TS_W), .NBKT(NBKT), .BKT_W(BKT_W), .BKT_SHIFT(BKT_SHIFT)
        ) u_bk (
            .value (dv[k]),
            .bucket(bv[k])
        );
    end

    always_comb begin
        for (int t = 0; t < NUM_TYPES; t++) begin
            type_hit_v[t]    = rec_valid && (rec_type == TYPE_W'(t));
            hit_type_inc[t]  = type_hit_v[t] && !rec_miss;
            miss_type_inc[t] = type_hit_v[t] && rec_miss;
            type_bkt[t]      = bv[0];
        end
        for (int r = 0; r < NUM_RESP; r++) begin
            resp_hit_v[r]    = rec_valid && (rec_resp == RESP_W'(r));
            hit_resp_inc[r]  = resp_hit_v[r] && !rec_miss;
            miss_resp_inc[r] = resp_hit_v[r] && rec_miss;
            incomp_inc[r]    = miss_resp_inc[r] && !ordered;
            resp_bkt[r]      = bv[0];
            incomp_bkt[r]    = 1'b0;
            for (int k = 0; k < NSEG; k++) begin
                seg_inc[r*NSEG+k] = miss_resp_inc[r] && ordered;
                seg_bkt[r*NSEG+k] = bv[k+1];
            end
        end
    end

    lat_hist_bank #(.NH(1), .NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_all (
        .clk(clk), .rst_n(rst_n), .inc(rec_valid), .bkt(bv[0]),
        .rd_hist(rd_index), .rd_bkt(rd_bucket), .rd_cnt(c_all)
    );

    lat_hist_bank #(.NH(NUM_TYPES), .NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_type (
        .clk(clk), .rst_n(rst_n), .inc(type_hit_v), .bkt(type_bkt),
        .rd_hist(rd_index), .rd_bkt(rd_bucket), .rd_cnt(c_type)
    );

    lat_hist_bank #(.NH(NUM_TYPES), .NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_htype (
        .clk(clk), .rst_n(rst_n), .inc(hit_type_inc), .bkt(type_bkt),
        .rd_hist(rd_index), .rd_bkt(rd_bucket), .rd_cnt(c_htype)
    );

    lat_hist_bank #(.NH(NUM_TYPES), .NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_mtype (
        .clk(clk), .rst_n(rst_n), .inc(miss_type_inc), .bkt(type_bkt),
        .rd_hist(rd_index), .rd_bkt(rd_bucket), .rd_cnt(c_mtype)
    );

    lat_hist_bank #(.NH(NUM_RESP), .NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_hresp (
        .clk(clk), .rst_n(rst_n), .inc(hit_resp_inc), .bkt(resp_bkt),
        .rd_hist(rd_index), .rd_bkt(rd_bucket), .rd_cnt(c_hresp)
    );

    lat_hist_bank #(.NH(NUM_RESP), .NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_mresp (
        .clk(clk), .rst_n(rst_n), .inc(miss_resp_inc), .bkt(resp_bkt),
        .rd_hist(rd_index), .rd_bkt(rd_bucket), .rd_cnt(c_mresp)
    );

    lat_hist_bank #(.NH(NSEGH), .NBKT(NBKT), .BKT_W(BKT_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seg (
        .clk(clk), .rst_n(rst_n), .inc(seg_inc), .bkt(seg_bkt),
        .rd_hist(rd_index), .rd_bkt(rd_bucket), .rd_cnt(c_seg)
    );

    lat_hist_bank #(.NH(NUM_RESP), .NBKT(1), .BKT_W(1), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_incomp (
        .clk(clk), .rst_n(rst_n), .inc(incomp_inc), .bkt(incomp_bkt),
        .rd_hist(rd_index), .rd_bkt(1'b0), .rd_cnt(c_inc)
    );

    always_comb begin
        case (rd_group)
            G_ALL:       rd_count = c_all;
            G_TYPE:      rd_count = c_type;
            G_HIT_TYPE:  rd_count = c_htype;
            G_MISS_TYPE: rd_count = c_mtype;
            G_HIT_RESP:  rd_count = c_hresp;
            G_MISS_RESP: rd_count = c_mresp;
            G_SEG:       rd_count = c_seg;
            default:     rd_count = c_inc;
        endcase
    end

endmodule

// File: rtl/lat_breakdown_prof_chk.sv
module lat_breakdown_prof_chk #(
    parameter int NUM_RESP = 3,
    parameter int NBKT     = 10,
    parameter int CNT_W    = 16,
    parameter int RESP_W   = 2,
    parameter int IDX_W    = 4,
    parameter int BKT_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_valid,
    input logic [RESP_W-1:0] rec_resp,
    input logic              rec_miss,
    input logic [2:0]        rd_group,
    input logic [IDX_W-1:0]  rd_index,
    input logic [BKT_W-1:0]  rd_bucket,
    input logic [CNT_W-1:0]  rd_count
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [3+IDX_W+BKT_W-1:0] sel;
    assign sel = {rd_group, rd_index, rd_bucket};

    p_rd_bucket_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_group != 3'd7) && (int'(rd_bucket) >= NBKT)) |-> (rd_count == '0));

    p_count_monotone_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (!$stable(sel) || (rd_count >= $past(rd_count))));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count == CMAX) |=> (!$stable(sel) || (rd_count == CMAX)));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |=> (!$stable(sel) || $stable(rd_count)));

    p_no_resp_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (int'(rec_resp) >= NUM_RESP) && (rd_group >= 3'd4))
        |=> (!$stable(sel) || $stable(rd_count)));

    p_hit_no_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_miss &&
         ((rd_group == 3'd3) || (rd_group == 3'd5) || (rd_group == 3'd6) || (rd_group == 3'd7)))
        |=> (!$stable(sel) || $stable(rd_count)));

endmodule

bind lat_breakdown_prof lat_breakdown_prof_chk #(
    .NUM_RESP(NUM_RESP), .NBKT(NBKT), .CNT_W(CNT_W),
    .RESP_W(RESP_W), .IDX_W(IDX_W), .BKT_W(BKT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_resp(rec_resp),
    .rec_miss(rec_miss), .rd_group(rd_group), .rd_index(rd_index),
    .rd_bucket(rd_bucket), .rd_count(rd_count)
);

// File: tb/sim_lat_breakdown_prof.sv
`timescale 1ns/1ps
module sim_lat_breakdown_prof;

    localparam int NT = 3;
    localparam int NR = 2;
    localparam int NB = 10;
    localparam int SH = 1;
    localparam int CMAXV = 15;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rec_valid;
    logic [1:0] rec_type;
    logic [1:0] rec_resp;
    logic       rec_miss;
    logic [7:0] ts_issue, ts_init, ts_fwd, ts_first, ts_done;
    logic [2:0] rd_group;
    logic [3:0] rd_index;
    logic [3:0] rd_bucket;
    logic [3:0] rd_count;

    int checks = 0;
    int fails = 0;
    int m [8][10][10];

    always #4 clk = ~clk;

    lat_breakdown_prof #(
        .NUM_TYPES(NT), .NUM_RESP(NR), .TS_W(8), .NBKT(NB), .BKT_SHIFT(SH), .CNT_W(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_type(rec_type),
        .rec_resp(rec_resp), .rec_miss(rec_miss), .ts_issue(ts_issue),
        .ts_init(ts_init), .ts_fwd(ts_fwd), .ts_first(ts_first), .ts_done(ts_done),
        .rd_group(rd_group), .rd_index(rd_index), .rd_bucket(rd_bucket),
        .rd_count(rd_count)
    );

    function automatic int bk(input int v);
        int s;
        s = (v & 255) >> SH;
        return (s >= NB - 1) ? NB - 1 : s;
    endfunction

    function automatic int grp_size(input int g);
        case (g)
            0: return 1;
            1, 2, 3: return NT;
            4, 5, 7: return NR;
            default: return 4 * NR;
        endcase
    endfunction

    function automatic int expect_cnt(input int g, input int i, input int b);
        if (i >= grp_size(g)) return 0;
        if (g == 7) return m[7][i][0];
        if (b >= NB) return 0;
        return m[g][i][b];
    endfunction

    task automatic bump(input int g, input int i, input int b);
        if (m[g][i][b] < CMAXV) m[g][i][b]++;
    endtask

    task automatic model_clear();
        for (int g = 0; g < 8; g++)
            for (int i = 0; i < 10; i++)
                for (int b = 0; b < 10; b++)
                    m[g][i][b] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic send(input int ty, input int rs, input int ms,
                        input int t0, input int t1, input int t2, input int t3, input int t4);
        int tot;
        bit ord;
        @(negedge clk);
        rec_valid = 1'b1;
        rec_type  = 2'(ty);
        rec_resp  = 2'(rs);
        rec_miss  = 1'(ms);
        ts_issue  = 8'(t0);
        ts_init   = 8'(t1);
        ts_fwd    = 8'(t2);
        ts_first  = 8'(t3);
        ts_done   = 8'(t4);
        @(negedge clk);
        rec_valid = 1'b0;
        tot = (t4 - t0) & 255;
        ord = (t0 <= t1) && (t1 <= t2) && (t2 <= t3) && (t3 <= t4);
        bump(0, 0, bk(tot));
        if (ty < NT) begin
            bump(1, ty, bk(tot));
            bump(ms ? 3 : 2, ty, bk(tot));
        end
        if (rs < NR) begin
            bump(ms ? 5 : 4, rs, bk(tot));
            if (ms) begin
                if (ord) begin
                    bump(6, rs * 4 + 0, bk(t1 - t0));
                    bump(6, rs * 4 + 1, bk(t2 - t1));
                    bump(6, rs * 4 + 2, bk(t3 - t2));
                    bump(6, rs * 4 + 3, bk(t4 - t3));
                end else begin
                    bump(7, rs, 0);
                end
            end
        end
    endtask

    task automatic sweep(input string tag);
        for (int g = 0; g < 8; g++)
            for (int i = 0; i < 10; i++)
                for (int b = 0; b < 12; b++) begin
                    @(negedge clk);
                    rd_group  = 3'(g);
                    rd_index  = 4'(i);
                    rd_bucket = 4'(b);
                    #1;
                    checks++;
                    if (int'(rd_count) != expect_cnt(g, i, b)) begin
                        fails++;
                        $display("FAIL %s grp=%0d idx=%0d bkt=%0d actual=%0d expected=%0d",
                                 tag, g, i, b, rd_count, expect_cnt(g, i, b));
                    end
                end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(64'd8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int tots [9] = '{0, 1, 2, 5, 17, 18, 19, 40, 200};
        rst_n = 1'b0;
        rec_valid = 1'b0;
        rec_type = '0; rec_resp = '0; rec_miss = 1'b0;
        ts_issue = '0; ts_init = '0; ts_fwd = '0; ts_first = '0; ts_done = '0;
        rd_group = '0; rd_index = '0; rd_bucket = '0;
        model_clear();
        do_reset();

        // R9 R10: everything clear after reset, out-of-range reads zero
        sweep("R9 R10 reset state");

        // R12: idle cycles with busy record inputs
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            rec_type = 2'(c); rec_resp = 2'(c >> 1); rec_miss = 1'(c);
            ts_issue = 8'(c * 7); ts_done = 8'(c * 13 + 40);
            ts_init = 8'(c); ts_fwd = 8'(c + 3); ts_first = 8'(c + 9);
        end
        sweep("R12 idle");

        // R1 R2 R4 R7 R11: hits over every type, responder and bucket range
        for (int ty = 0; ty < 4; ty++)
            for (int rs = 0; rs < 4; rs++)
                for (int k = 0; k < 9; k++)
                    send(ty, rs, 0, ty * 3, 0, 0, 0, ty * 3 + tots[k]);
        sweep("R1 R2 R4 R7 R8 R11 hits");
        do_reset();

        // R3 R5: ordered misses, segment split
        for (int rs = 0; rs < 4; rs++)
            for (int p = 0; p < 4; p++) begin
                int a, b, c, e;
                case (p)
                    0: begin a = 0;  b = 0; c = 0; e = 0;  end
                    1: begin a = 1;  b = 3; c = 7; e = 30; end
                    2: begin a = 19; b = 2; c = 0; e = 5;  end
                    default: begin a = 4; b = 4; c = 4; e = 4; end
                endcase
                send(p, rs, 1, 5, 5 + a, 5 + a + b, 5 + a + b + c, 5 + a + b + c + e);
            end
        sweep("R3 R4 R5 R7 ordered misses");
        do_reset();

        // R6: out-of-order misses, one break in each position
        for (int rs = 0; rs < 4; rs++) begin
            send(0, rs, 1, 10, 9, 20, 30, 40);
            send(1, rs, 1, 10, 12, 11, 30, 40);
            send(2, rs, 1, 10, 12, 14, 13, 40);
            send(0, rs, 1, 10, 12, 14, 50, 49);
            send(1, rs, 1, 10, 11, 12, 13, 14);
        end
        sweep("R6 R4 out-of-order misses");
        do_reset();

        // R8: saturation under repetition, hits and out-of-order misses
        for (int n = 0; n < 20; n++) begin
            send(0, 0, 0, 2, 0, 0, 0, 8);
            send(1, 1, 1, 20, 19, 21, 22, 23);
        end
        sweep("R8 saturation");

        // R9: reset clears saturated counts
        do_reset();
        sweep("R9 clear after use");

        summary();
        $finish;
    end

endmodule